// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Sequencer

This block is the control engine behind a single granted DMA channel. When the arbiter hands it a channel number and a start pulse, it fetches that channel's descriptor from a table in system memory: a control word, a source end pointer and a destination end pointer. It then copies words one read/write pair at a time over a simple memory master port. After a round of transfers sized by the descriptor's arbitration exponent, or when the count runs out, it writes the updated control word back. It then returns to idle, or passes through a done state when the whole transfer is complete.

Two descriptor tables exist. The primary table sits at a 256-byte aligned base taken from a programmable pointer. The alternate table lies directly after it, at a fixed distance derived from the channel count. Descriptor and control-word accesses carry protection attributes from a global 3-bit configuration. Data reads and writes instead take their attributes from fields in the control word. The current state is exported as a 4-bit code for a status register. A bus error on any access aborts the transfer and raises a sticky error flag.

Top module: `dma_seq`

## Requirements
- R1: After reset the sequencer is in state 0 (idle), `mem_req`, `xfer_done` and `bus_err` are low.
- R2: A `start` pulse is accepted only in idle with `enable` high. It latches `chan_sel` and `alt_sel`. A start while `enable` is low leaves the sequencer idle and issues no access.
- R3: The table base is `{tbl_base[31:8], 8'h00}`; the alternate table adds 16 × NCH. A channel's descriptor is at table + 16 × channel, with source end pointer at +0, destination end pointer at +4 and control word at +8. It is read control word first (state 1), then source end (state 2), then destination end (state 3).
- R4: Control word fields: [2:0] mode (0 = stopped, 7 = peripheral scatter-gather, other values = basic), [7:4] arbitration exponent R, [17:8] remaining transfers minus one, [20:18] source data protection, [23:21] destination data protection.
- R5: With k the current remaining-minus-one count, each transfer reads the source end pointer − 4k (state 4), then writes that word to the destination end pointer − 4k (state 5). Words land in ascending address order, and nothing past the end pointer is written.
- R6: A round ends after 2^R transfers (R above 10 counts as 2^11) or at the last transfer. The control word is then written back at +8 (state 7). For an unfinished transfer the write-back holds the new remaining-minus-one count with all other bits unchanged, and the sequencer returns to idle with no done pulse.
- R7: When the last transfer completes, the write-back clears [17:8] and [2:0] and keeps the other bits. The sequencer then spends exactly one cycle in state 9 with `xfer_done` high and returns to idle.
- R8: A control word with mode 0 sends the sequencer from state 1 straight back to idle, with no further access and no done pulse.
- R9: A finished transfer in mode 7 passes through state 0xA for one cycle before state 9.
- R10: `mem_prot` (attributes cacheable, bufferable, privileged from bit 2 to bit 0) equals `desc_prot` for descriptor and write-back accesses. It takes the source field for data reads and the destination field for data writes.
- R11: With `wait_on_req` high and `chan_req` still asserted at the end of a round, the sequencer waits in state 6 with no access until `chan_req` falls, then writes back.
- R12: If `enable` is low when a new source read would begin, the sequencer waits in state 8 with no access. It resumes at state 4 once `enable` returns.
- R13: An access that completes with `mem_err` sets `bus_err` and returns the sequencer to idle, with no write-back and no done pulse. `bus_err` stays set until `err_clr`.
- R14: An access is held, with address, direction and data stable, until `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global controller enable |
| start | input | 1 | Grant pulse for the channel on `chan_sel` |
| chan_sel | input | CH_W | Granted channel number |
| alt_sel | input | 1 | Use the alternate descriptor table |
| chan_req | input | 1 | Channel request line, still asserted |
| wait_on_req | input | 1 | Hold the channel until its request drops |
| tbl_base | input | 24 | Primary table base, address bits [31:8] |
| desc_prot | input | 3 | Protection for descriptor accesses |
| err_clr | input | 1 | Clears the bus error flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access completes with a bus error |
| mem_prot | output | 3 | Protection attributes of the access |
| seq_state | output | 4 | Current state code |
| xfer_done | output | 1 | Transfer finished pulse |
| bus_err | output | 1 | Sticky bus error flag |

## Verification
The bench goes after round boundaries: counts that do and do not divide by 2^R, and the one-transfer descriptor. A design that miscounted the round would copy too many words or write back a wrong remaining count. Alternate-table and channel-offset runs surround each descriptor with sentinel slots, so a wrong table address shows up as a sentinel being consumed or overwritten. Stall, wait-on-request, mode-0 and mid-transfer bus-error runs check that the sequencer really parks or aborts: an engine that leaked an access, wrote back after an error or pulsed done would be counted. Random memory wait states test that every access is held stable until accepted and carries the right protection bits.

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            start,
  input  logic [CH_W-1:0] chan_sel,
  input  logic            alt_sel,
  input  logic            chan_req,
  input  logic            wait_on_req,
  input  logic [31:8]     tbl_base,
  input  logic [2:0]      desc_prot,
  input  logic            err_clr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ready,
  input  logic            mem_err,
  output logic [2:0]      mem_prot,
  output logic [3:0]      seq_state,
  output logic            xfer_done,
  output logic            bus_err
);
  localparam logic [31:0] ALT_OFS = 32'(16 * NCH);
  localparam int CNT_W = 10;

  typedef enum logic [3:0] {
    S_IDLE = 4'h0, S_RCTL = 4'h1, S_RSRC = 4'h2, S_RDST = 4'h3,
    S_RDAT = 4'h4, S_WDAT = 4'h5, S_WREQ = 4'h6, S_WCTL = 4'h7,
    S_STAL = 4'h8, S_DONE = 4'h9, S_SGTR = 4'hA
  } st_t;

  st_t             st, nxt;
  logic [CH_W-1:0] ch;
  logic            alt, fin;
  logic [31:0]     ctrl, src_end, dst_end, dat;
  logic [CNT_W-1:0] rem;
  logic [10:0]     bcnt, rlim;
  logic [31:0]     tbl, desc, wb;
  logic            ac, ok, last, rend;

  assign tbl  = {tbl_base, 8'h00} + (alt ? ALT_OFS : 32'd0);
  assign desc = tbl + (32'(ch) << 4);
  assign rlim = (ctrl[7:4] > 4'd10) ? 11'h7FF : ((11'd1 << ctrl[7:4]) - 11'd1);
  assign last = (rem == '0);
  assign rend = last || (bcnt == rlim);
  assign wb   = fin ? {ctrl[31:18], {CNT_W{1'b0}}, ctrl[7:3], 3'b000}
                    : {ctrl[31:18], rem, ctrl[7:0]};

  assign ac = mem_req && mem_ready;
  assign ok = ac && !mem_err;

  assign mem_req = (st == S_RCTL) || (st == S_RSRC) || (st == S_RDST) ||
                   (st == S_RDAT) || (st == S_WDAT) || (st == S_WCTL);
  assign mem_we  = (st == S_WDAT) || (st == S_WCTL);
  assign mem_wdata = (st == S_WDAT) ? dat : (st == S_WCTL) ? wb : 32'd0;
  assign mem_prot  = (st == S_RDAT) ? ctrl[20:18] :
                     (st == S_WDAT) ? ctrl[23:21] : desc_prot;
  assign seq_state = st;
  assign xfer_done = (st == S_DONE);

  always_comb begin
    case (st)
      S_RCTL, S_WCTL: mem_addr = desc + 32'd8;
      S_RSRC:         mem_addr = desc;
      S_RDST:         mem_addr = desc + 32'd4;
      S_RDAT:         mem_addr = src_end - (32'(rem) << 2);
      S_WDAT:         mem_addr = dst_end - (32'(rem) << 2);
      default:        mem_addr = 32'd0;
    endcase
  end

  always_comb begin
    nxt = st;
    if (ac && mem_err) nxt = S_IDLE;
    else begin
      case (st)
        S_IDLE: if (start && enable) nxt = S_RCTL;
        S_RCTL: if (ok) nxt = (mem_rdata[2:0] == 3'd0) ? S_IDLE : S_RSRC;
        S_RSRC: if (ok) nxt = S_RDST;
        S_RDST: if (ok) nxt = enable ? S_RDAT : S_STAL;
        S_STAL: if (enable) nxt = S_RDAT;
        S_RDAT: if (ok) nxt = S_WDAT;
        S_WDAT: if (ok) begin
          if (rend) nxt = (wait_on_req && chan_req) ? S_WREQ : S_WCTL;
          else      nxt = enable ? S_RDAT : S_STAL;
        end
        S_WREQ: if (!chan_req) nxt = S_WCTL;
        S_WCTL: if (ok) nxt = fin ? ((ctrl[2:0] == 3'd7) ? S_SGTR : S_DONE) : S_IDLE;
        S_SGTR: nxt = S_DONE;
        S_DONE: nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ch <= '0; alt <= 1'b0; fin <= 1'b0;
      ctrl <= '0; src_end <= '0; dst_end <= '0; dat <= '0;
      rem <= '0; bcnt <= '0; bus_err <= 1'b0;
    end else begin
      st <= nxt;
      if (ac && mem_err) bus_err <= 1'b1;
      else if (err_clr)  bus_err <= 1'b0;
      case (st)
        S_IDLE: if (start && enable) begin
          ch <= chan_sel; alt <= alt_sel; fin <= 1'b0;
        end
        S_RCTL: if (ok) begin ctrl <= mem_rdata; rem <= mem_rdata[17:8]; end
        S_RSRC: if (ok) src_end <= mem_rdata;
        S_RDST: if (ok) begin dst_end <= mem_rdata; bcnt <= '0; end
        S_RDAT: if (ok) dat <= mem_rdata;
        S_WDAT: if (ok) begin
          if (last) fin <= 1'b1;
          else begin rem <= rem - 1'b1; bcnt <= bcnt + 1'b1; end
        end
        default: ;
      endcase
    end
  end

  // R2: no start taken while disabled
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> (st == S_IDLE));
  // R3: control word slot is offset 8 within a 16-byte descriptor
  a_r3_ctl_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RCTL || st == S_WCTL) |-> (mem_addr[3:0] == 4'h8));
  // R7: done only follows a write-back or the scatter-gather pass-through
  a_r7_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> ($past(st) == S_WCTL || $past(st) == S_SGTR));
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (st == S_IDLE));
  // R8: stopped descriptor goes back to idle
  a_r8_stop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RCTL && mem_ready && !mem_err && mem_rdata[2:0] == 3'd0) |=> (st == S_IDLE));
  // R9: pass-through lasts one cycle
  a_r9_sg_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SGTR) |=> (st == S_DONE));
  // R11: held while request persists
  a_r11_wait_req: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WREQ && chan_req) |=> (st == S_WREQ && !mem_req));
  // R12: stalled without access until enabled
  a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAL && !enable) |=> (st == S_STAL && !mem_req));
  // R13: error aborts and flags
  a_r13_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> (st == S_IDLE && bus_err));
  // R14: pending access held stable
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/test_dma_seq.sv
module test_dma_seq;
  localparam int NCH = 8;
  localparam int CH_W = 3;
  localparam logic [31:0] PBASE = 32'h0000_0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, start = 1'b0, alt_sel = 1'b0, chan_req = 1'b0, wait_on_req = 1'b0;
  logic err_clr = 1'b0;
  logic [CH_W-1:0] chan_sel = '0;
  logic [31:8] tbl_base = PBASE[31:8];
  logic [2:0] desc_prot = 3'b101;
  logic mem_req, mem_we, mem_ready = 1'b0, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0] mem_prot;
  logic [3:0] seq_state;
  logic xfer_done, bus_err;

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_bad = 0, done_cnt = 0, acc_cnt = 0;
  logic saw_sg = 1'b0, err_on = 1'b0, hold_chk = 1'b0, finished = 1'b0;
  logic [31:0] err_addr = '0, hold_addr = '0;
  logic [2:0] cur_sp = '0, cur_dp = '0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_err = err_on && mem_req && (mem_addr == err_addr);

  dma_seq #(.NCH(NCH)) i_dma_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .chan_sel(chan_sel),
    .alt_sel(alt_sel), .chan_req(chan_req), .wait_on_req(wait_on_req), .tbl_base(tbl_base),
    .desc_prot(desc_prot), .err_clr(err_clr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_err(mem_err), .mem_prot(mem_prot), .seq_state(seq_state), .xfer_done(xfer_done),
    .bus_err(bus_err));

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and access monitor, away from the rising edge
  always @(negedge clk) begin
    logic rdy_n;
    logic [2:0] ep;
    if (xfer_done) done_cnt++;
    if (seq_state == 4'hA) saw_sg = 1'b1;
    if (hold_chk && rst_n)
      chk(mem_req && mem_addr == hold_addr, "R14 held access", mem_addr, hold_addr);
    rdy_n = ($urandom % 4) != 0;
    if (mem_req && rdy_n && rst_n) begin
      acc_cnt++;
      ep = (mem_addr >= 32'h200 && mem_addr < 32'h300) ? desc_prot : (mem_we ? cur_dp : cur_sp);
      chk(mem_prot == ep, "R10 protection", 32'(mem_prot), 32'(ep));
      if (mem_we && !mem_err) mem[mem_addr[11:2]] = mem_wdata;
    end
    hold_chk = mem_req && !rdy_n;
    hold_addr = mem_addr;
    mem_ready = rdy_n;
  end

  function automatic logic [31:0] mk_ctrl(int n, int r, logic [2:0] mode, logic [2:0] sp, logic [2:0] dp);
    logic [9:0] c = 10'(n - 1);
    return {8'h00, dp, sp, c, 4'(r), 1'b0, mode};
  endfunction

  function automatic logic [31:0] exp_wb(logic [31:0] c, int left);
    if (left == 0) return {c[31:18], 10'd0, c[7:3], 3'b000};
    return {c[31:18], 10'(left - 1), c[7:0]};
  endfunction

  function automatic int n_rounds(int n, int r);
    return (n + (1 << r) - 1) >> r;
  endfunction

  function automatic logic [31:0] dslot(int ch, bit alt);
    return PBASE + (alt ? 32'(16 * NCH) : 32'd0) + 32'(16 * ch);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (seq_state != 4'h0 && k < 5000) begin tick(); k++; end
    if (k >= 5000) chk(1'b0, req, 32'(seq_state), 32'h0);
  endtask

  task automatic pulse_start(input int ch, input bit alt);
    chan_sel = CH_W'(ch); alt_sel = alt; start = 1'b1;
    tick();
    start = 1'b0;
    tick();
  endtask

  task automatic setup(input int ch, input bit alt, input int n, input int r, input logic [2:0] mode,
                       input logic [2:0] sp, input logic [2:0] dp, input int soff, input int doff,
                       output logic [31:0] ctl);
    logic [31:0] d = dslot(ch, alt);
    logic [31:0] sa = 32'h400 + 32'(soff * 4), da = 32'h800 + 32'(doff * 4);
    for (int i = 0; i < 2 * NCH * 4; i++) mem[(PBASE >> 2) + i] = 32'hDEAD_0000 + i;
    for (int i = 0; i < 64; i++) begin
      mem[(sa >> 2) + i] = $urandom;
      mem[(da >> 2) + i] = 32'hCAFE_0000 + i;
    end
    ctl = mk_ctrl(n, r, mode, sp, dp);
    mem[d >> 2] = sa + 32'(4 * (n - 1));
    mem[(d >> 2) + 1] = da + 32'(4 * (n - 1));
    mem[(d >> 2) + 2] = ctl;
    cur_sp = sp; cur_dp = dp;
  endtask

  task automatic run_desc(input int ch, input bit alt, input int n, input int r,
                          input logic [2:0] mode, input string tag);
    logic [31:0] ctl, d, sa, da;
    int soff = $urandom % 32, doff = $urandom % 32, d0, left, ok;
    logic [2:0] sp = 3'($urandom), dp = 3'($urandom);
    setup(ch, alt, n, r, mode, sp, dp, soff, doff, ctl);
    d = dslot(ch, alt);
    sa = 32'h400 + 32'(soff * 4); da = 32'h800 + 32'(doff * 4);
    d0 = done_cnt; left = n;
    for (int k = 0; k < n_rounds(n, r); k++) begin
      pulse_start(ch, alt);
      wait_idle({tag, " R6 round ends"});
      left = left - ((left < (1 << r)) ? left : (1 << r));
      chk(mem[(d >> 2) + 2] == exp_wb(ctl, left), {tag, " R6/R7 write-back"}, mem[(d >> 2) + 2], exp_wb(ctl, left));
      if (left != 0) chk(done_cnt == d0, {tag, " R6 no done mid-transfer"}, 32'(done_cnt - d0), 0);
    end
    ok = 1;
    for (int i = 0; i < n; i++) if (mem[(da >> 2) + i] != mem[(sa >> 2) + i]) ok = 0;
    chk(ok == 1, {tag, " R5 data copied"}, 32'(ok), 1);
    chk(mem[(da >> 2) + n] == 32'hCAFE_0000 + n, {tag, " R5 no write past end"},
        mem[(da >> 2) + n], 32'hCAFE_0000 + n);
    chk(done_cnt == d0 + 1, {tag, " R7 one done pulse"}, 32'(done_cnt - d0), 1);
    chk(mem[(dslot(ch, !alt) >> 2) + 2] == 32'hDEAD_0000 + ((dslot(ch, !alt) - PBASE) >> 2) + 2,
        {tag, " R3 other table untouched"}, mem[(dslot(ch, !alt) >> 2) + 2], 32'hDEAD_0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..R14 run hung: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ctl;
    int a0, d0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) tick();
    chk(seq_state == 4'h0 && !mem_req && !xfer_done && !bus_err, "R1 reset state",
        {seq_state, 25'd0, mem_req, xfer_done, bus_err}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2: start ignored while disabled
    setup(2, 0, 4, 2, 3'd1, 3'b000, 3'b000, 0, 0, ctl);
    enable = 1'b0; a0 = acc_cnt;
    pulse_start(2, 0);
    repeat (4) tick();
    chk(seq_state == 4'h0 && acc_cnt == a0, "R2 start ignored when disabled", 32'(acc_cnt - a0), 0);
    enable = 1'b1;

    // directed rounds: R3/R4/R5/R6/R7
    run_desc(0, 0, 1, 0, 3'd1, "single");
    run_desc(3, 0, 8, 2, 3'd2, "even rounds");
    run_desc(7, 1, 7, 1, 3'd1, "odd count alt");
    run_desc(5, 1, 20, 11, 3'd1, "R4 capped exponent");

    // R8: stopped mode
    setup(4, 0, 5, 1, 3'd0, 3'b011, 3'b110, 0, 0, ctl);
    a0 = acc_cnt; d0 = done_cnt;
    pulse_start(4, 0);
    wait_idle("R8 stop returns");
    chk(acc_cnt == a0 + 1, "R8 only control read", 32'(acc_cnt - a0), 1);
    chk(done_cnt == d0 && mem[32'h800 >> 2] == 32'hCAFE_0000, "R8 no done no data", 32'(done_cnt - d0), 0);

    // R9: scatter-gather pass-through
    saw_sg = 1'b0;
    run_desc(6, 0, 3, 2, 3'd7, "sg");
    chk(saw_sg == 1'b1, "R9 state A visited", 32'(saw_sg), 1);

    // R11: wait on request
    setup(1, 0, 1, 0, 3'd1, 3'b001, 3'b010, 0, 0, ctl);
    wait_on_req = 1'b1; chan_req = 1'b1; d0 = done_cnt;
    pulse_start(1, 0);
    begin
      int k = 0;
      while (seq_state != 4'h6 && k < 2000) begin tick(); k++; end
    end
    repeat (5) tick();
    chk(seq_state == 4'h6 && !mem_req, "R11 parked in state 6", 32'(seq_state), 32'h6);
    chk(mem[(dslot(1, 0) >> 2) + 2] == ctl, "R11 no write-back while request held", mem[(dslot(1, 0) >> 2) + 2], ctl);
    chan_req = 1'b0;
    wait_idle("R11 resumes");
    chk(done_cnt == d0 + 1, "R11 completes", 32'(done_cnt - d0), 1);
    wait_on_req = 1'b0;

    // R12: stall
    setup(2, 1, 6, 3, 3'd1, 3'b100, 3'b001, 3, 5, ctl);
    d0 = done_cnt;
    pulse_start(2, 1);
    begin
      int k = 0;
      while (seq_state != 4'h5 && k < 2000) begin tick(); k++; end
    end
    enable = 1'b0;
    begin
      int k = 0;
      while (seq_state != 4'h8 && k < 2000) begin tick(); k++; end
    end
    a0 = acc_cnt;
    repeat (6) tick();
    chk(seq_state == 4'h8 && acc_cnt == a0, "R12 stalled without access", 32'(seq_state), 32'h8);
    enable = 1'b1;
    wait_idle("R12 resumes");
    chk(mem[(32'h800 >> 2) + 5 + 5] == mem[(32'h400 >> 2) + 3 + 5], "R12 data after stall",
        mem[(32'h800 >> 2) + 10], mem[(32'h400 >> 2) + 8]);
    chk(done_cnt == d0 + 1, "R12 completes", 32'(done_cnt - d0), 1);

    // R13: bus error mid-transfer
    setup(3, 0, 4, 2, 3'd1, 3'b010, 3'b011, 0, 0, ctl);
    err_addr = 32'h404; err_on = 1'b1; d0 = done_cnt;
    pulse_start(3, 0);
    wait_idle("R13 abort");
    err_on = 1'b0;
    chk(bus_err == 1'b1, "R13 flag set", 32'(bus_err), 1);
    chk(done_cnt == d0, "R13 no done", 32'(done_cnt - d0), 0);
    chk(mem[(dslot(3, 0) >> 2) + 2] == ctl, "R13 no write-back", mem[(dslot(3, 0) >> 2) + 2], ctl);
    repeat (3) tick();
    chk(bus_err == 1'b1, "R13 flag sticky", 32'(bus_err), 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0; tick();
    chk(bus_err == 1'b0, "R13 flag cleared", 32'(bus_err), 0);

    // random descriptors
    for (int t = 0; t < 24; t++) begin
      desc_prot = 3'($urandom);
      run_desc(int'($urandom % NCH), bit'($urandom % 2), 1 + int'($urandom % 20),
               int'($urandom % 6), 3'(1 + $urandom % 6), "random");
    end

    finish_run();
  end
endmodule